// File: doc/BRIEF.md
# Addressable Tap Delay Line

This block is a serial delay line with a fixed physical depth of 16 one-bit stages. A 4-bit tap select picks which stage drives the single output bit, so the delay seen between the serial input and the output runs from one to sixteen clock edges. The select can stay fixed to give a constant delay. It can also be moved at any moment to give a variable delay, and moving it never flushes or disturbs the stored bits.

The stages power up holding a preset pattern taken from a parameter, and there is no reset. A clock-enable input can freeze shifting. There is no valid/ready handshake on this block. The serial input is taken on every rising edge while the enable is high, so the enable is the only way to stall the line, and the output is always valid. The output is a purely combinational function of the stored bits and the select. A change of select therefore shows up on the output within the same cycle.

Top module: `tap_delay_line`

## Requirements
- R1: The line always holds DEPTH (default 16) stages. The output equals the stage whose index equals the select value, so the select value s gives a delay of s+1 enabled clock edges.
- R2: On each rising clock edge with the enable high, stage 0 takes the serial input and stage i takes the former content of stage i-1, for every i from 1 to DEPTH-1.
- R3: The bit leaving the last stage is dropped. With the select at all ones, the output is the input from exactly 16 enabled edges earlier.
- R4: Bit i of the INIT_VAL parameter is the power-up content of stage i, so bit 15 presets the last stage. The default is all zeros. Before the first shift, the output equals INIT_VAL[select] for every select value.
- R5: A change of select takes effect in the same cycle, is purely combinational, and leaves the stored stages untouched.
- R6: With the enable low, a rising edge changes no stage. The output still follows the select over the frozen contents.
- R7: With the low three select bits held at 1, toggling the top select bit switches the delay between 16 and 8 without losing data.
- R8: A select of 0 gives a one-edge delay and a select of 15 gives a sixteen-edge delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; shifting happens on the rising edge |
| shift_en_i | input | 1 | Active-high enable for shifting; tie high if not used |
| data_i | input | 1 | Serial data into stage 0 |
| tap_sel_i | input | 4 | Index of the stage that drives the output |
| data_o | output | 1 | Content of the selected stage |

## Verification
A corrupted stage stays hidden until the select points at it. The sweep of every fixed select with a pseudo-random stream therefore exposes a wrong bit in any stage within at most sixteen edges of its entry. A select path that is wrong shows up in the very cycle the select moves, because the output is combinational. This is why the output is compared right after each select change, before the next edge. A stall that leaks a shift shifts the whole stream by one position, and the reference queue model then sees a mismatch from the next compare onward.

// File: rtl/tap_delay_pkg.sv
package tap_delay_pkg;
  parameter int unsigned TAP_DEPTH_DEFAULT = 16;

  // Width of a select able to index every stage of a line of the given depth.
  function automatic int unsigned tap_sel_width(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/tap_stage_chain.sv
module tap_stage_chain #(
  parameter int unsigned DEPTH = tap_delay_pkg::TAP_DEPTH_DEFAULT,
  parameter logic [DEPTH-1:0] INIT_VAL = '0
) (
  input  logic             clk_i,
  input  logic             shift_en_i,
  input  logic             data_i,
  output logic [DEPTH-1:0] stages_o
);
  // One flop per stage, preset from its own bit of INIT_VAL, no reset.
  for (genvar g = 0; g < DEPTH; g++) begin : stage_g
    logic bit_q = INIT_VAL[g];
    if (g == 0) begin : head_g
      always_ff @(posedge clk_i) begin
        if (shift_en_i) bit_q <= data_i;
      end
    end else begin : body_g
      always_ff @(posedge clk_i) begin
        if (shift_en_i) bit_q <= stages_o[g-1];
      end
    end
    assign stages_o[g] = bit_q;
  end
endmodule

// File: rtl/tap_select_tree.sv
module tap_select_tree #(
  parameter int unsigned DEPTH = tap_delay_pkg::TAP_DEPTH_DEFAULT,
  localparam int unsigned SEL_W = tap_delay_pkg::tap_sel_width(DEPTH)
) (
  input  logic [DEPTH-1:0] stages_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tap_o
);
  // Binary 2:1 tree; level l halves the candidates using select bit l-1.
  // DEPTH must be a power of two.
  for (genvar l = 0; l <= SEL_W; l++) begin : lvl_g
    logic [(DEPTH>>l)-1:0] node;
    if (l == 0) begin : leaf_g
      assign node = stages_i;
    end else begin : mix_g
      for (genvar n = 0; n < (DEPTH>>l); n++) begin : pick_g
        assign node[n] = sel_i[l-1] ? lvl_g[l-1].node[2*n+1]
                                    : lvl_g[l-1].node[2*n];
      end
    end
  end

  assign tap_o = lvl_g[SEL_W].node[0];
endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line #(
  parameter int unsigned DEPTH = tap_delay_pkg::TAP_DEPTH_DEFAULT,
  parameter logic [DEPTH-1:0] INIT_VAL = '0,
  localparam int unsigned SEL_W = tap_delay_pkg::tap_sel_width(DEPTH)
) (
  input  logic             clk_i,
  input  logic             shift_en_i,
  input  logic             data_i,
  input  logic [SEL_W-1:0] tap_sel_i,
  output logic             data_o
);
  logic [DEPTH-1:0] stage_q;

  tap_stage_chain #(.DEPTH(DEPTH), .INIT_VAL(INIT_VAL)) u_chain (
    .clk_i      (clk_i),
    .shift_en_i (shift_en_i),
    .data_i     (data_i),
    .stages_o   (stage_q)
  );

  tap_select_tree #(.DEPTH(DEPTH)) u_tree (
    .stages_i (stage_q),
    .sel_i    (tap_sel_i),
    .tap_o    (data_o)
  );
endmodule

// File: rtl/tap_delay_line_chk.sv
module tap_delay_line_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned SEL_W = tap_delay_pkg::tap_sel_width(DEPTH)
) (
  input logic             clk_i,
  input logic             shift_en_i,
  input logic             data_i,
  input logic [SEL_W-1:0] tap_sel_i,
  input logic             data_o,
  input logic [DEPTH-1:0] stage_q
);
  // No reset exists; checks arm after the first edge so $past has history.
  logic armed = 1'b0;
  always_ff @(posedge clk_i) armed <= 1'b1;

  // R2
  head_capture_chk: assert property (@(posedge clk_i) disable iff (!armed)
    $past(shift_en_i) |-> stage_q[0] == $past(data_i));

  // R2
  chain_move_chk: assert property (@(posedge clk_i) disable iff (!armed)
    $past(shift_en_i) |-> stage_q[DEPTH-1:1] == $past(stage_q[DEPTH-2:0]));

  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!armed)
    !$past(shift_en_i) |-> $stable(stage_q));

  // R1
  tap_pick_chk: assert property (@(posedge clk_i) disable iff (!armed)
    data_o == stage_q[tap_sel_i]);
endmodule

bind tap_delay_line tap_delay_line_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .shift_en_i (shift_en_i),
  .data_i     (data_i),
  .tap_sel_i  (tap_sel_i),
  .data_o     (data_o),
  .stage_q    (stage_q)
);

// File: tb/tap_delay_line_bench.sv
`timescale 1ns/1ps
module tap_delay_line_bench;
  localparam logic [15:0] INIT = 16'h3A5C;

  logic       clk = 1'b0;
  logic       en = 1'b0;
  logic       din = 1'b0;
  logic [3:0] sel = 4'd0;
  logic       dout;
  bit         run = 1'b0;
  bit         done = 1'b0;
  int         checks = 0;
  int         errors = 0;
  bit         hist[$];
  logic [15:0] lfsr = 16'hACE1;

  tap_delay_line #(.DEPTH(16), .INIT_VAL(INIT)) u_tap_delay_line (
    .clk_i(clk), .shift_en_i(en), .data_i(din), .tap_sel_i(sel), .data_o(dout)
  );

  initial begin
    wait (run);
    forever #2 clk = ~clk;
  end

  function automatic bit next_bit();
    lfsr = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
    return lfsr[0];
  endfunction

  task automatic check(input string tag, input bit exp);
    checks++;
    if (dout !== exp) begin
      errors++;
      $display("FAIL %s: data_o=%b expected %b (sel=%0d)", tag, dout, exp, sel);
    end
  endtask

  // Drive at the falling edge, compare after settling, update model at the rise.
  task automatic step(input bit d, input logic [3:0] s, input bit e, input string tag);
    @(negedge clk);
    din = d; sel = s; en = e;
    #1 check(tag, hist[s]);
    @(posedge clk);
    if (e) begin
      hist.push_front(d);
      void'(hist.pop_back());
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) hist.push_back(INIT[i]);
    // R4: power-up contents, swept over every select before any edge
    for (int s = 0; s < 16; s++) begin
      sel = 4'(s);
      #1 check("R4", INIT[s]);
    end
    run = 1'b1;
    // R1 R8 R2 R3: every fixed select with a pseudo-random stream
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 40; k++)
        step(next_bit(), 4'(s), 1'b1, (s == 0) ? "R2/R8" : (s == 15) ? "R3/R8" : "R1");
    end
    // R7: top select bit toggles between delays 16 and 8
    for (int k = 0; k < 60; k++)
      step(next_bit(), ((k / 5) % 2 == 0) ? 4'd15 : 4'd7, 1'b1, "R7");
    // R5: select moves every cycle mid-stream
    for (int k = 0; k < 200; k++)
      step(next_bit(), 4'(next_bit() * 8 + next_bit() * 4 + next_bit() * 2 + next_bit()), 1'b1, "R5");
    // R6: stalled line, select still sweeps
    for (int k = 0; k < 32; k++)
      step(next_bit(), 4'(k % 16), 1'b0, "R6");
    for (int k = 0; k < 40; k++)
      step(next_bit(), 4'(k % 16), (k % 3) != 0, "R6");
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule